// File: doc/BRIEF.md
# DMA Physical Address Region Decoder

This block sits between the DMA channel engines and the memory system. Each cycle one channel may present a transfer address together with a direction bit. The block works out which target the address falls in: main RAM, a zero sink, the on-chip scratchpad, or a vector-unit memory window. It returns that region with a byte offset inside it. If the address maps to no target it returns a bus error instead. The result is registered and appears one cycle after the request strobe.

Two decode paths exist. Most channels use the normal path. There, a flag in the top address bit forces the scratchpad, and a small physical alias just above the I/O base also maps onto the scratchpad. One designated channel, the scratchpad-source channel, uses an alternate path. On that path, a pattern of three ones in the upper address bits selects the scratchpad, and a window high in the physical space reaches the vector-unit memory.

When an address fails to decode, the block raises a sticky bus-error flag and sets a sticky status bit for the requesting channel. For one cycle it also pulses a clear for that channel's start bit, which stops the channel. Memory arrays and the data movement itself live elsewhere.

Top module: `dma_addr_decoder`

## Requirements
- R1: Every response offset has bits 3:0 equal to zero, whatever the low four address bits were.
- R2: On the normal path (any channel other than SPAD_CH, default 8), an address with bit 31 set gives region code 3 (scratchpad) with offset `addr & 0x3FF0`.
- R3: Apart from the scratchpad-flag cases, the address is reduced to `addr & 0x1FFFFFF0` before comparison. A reduced address below MAIN_BYTES (default 0x0200_0000) gives region code 0 (main RAM) with offset equal to the reduced address.
- R4: A reduced address from MAIN_BYTES up to 0x0FFF_FFFF gives the zero-sink region with offset 0. The code is 1 for a read (req_write=0) and 2 for a write (req_write=1).
- R5: On the normal path, a reduced address in 0x1000_0000 to 0x1000_3FFF gives region code 3 with offset `addr & 0x3FF0`.
- R6: On the SPAD_CH path, an address whose bits 30:28 are 3'b111 gives region code 3 with offset `addr & 0x3FF0`, whatever bit 31 is. On that path bit 31 has no other special meaning.
- R7: On the SPAD_CH path, a reduced address in 0x1100_4000 to 0x1100_FFFF gives region code 4 (vector-unit window) with offset equal to the reduced address minus 0x1100_4000. The 0x1000_0000 alias of R5 does not apply on this path.
- R8: Any other address gives rsp_buserr=1, region code 7 and offset 0.
- R9: A bus error sets buserr_flag in the same cycle as the response, and the flag then stays set until reset.
- R10: A bus error sets chan_stat bit [req_ch] in the response cycle, and the bit stays set until reset. Other channels' bits are unchanged.
- R11: start_clr is one-hot at bit [req_ch] for exactly the response cycle of a bus error, and all zero otherwise.
- R12: rsp_valid is high in exactly the cycle after a cycle with req_valid high. After reset, rsp_valid, buserr_flag, chan_stat and start_clr are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Decode request strobe |
| req_addr | input | 32 | Transfer address |
| req_ch | input | CH_W (4) | Requesting channel number |
| req_write | input | 1 | 1 for a write transfer, 0 for a read |
| rsp_valid | output | 1 | Response valid, one cycle after req_valid |
| rsp_region | output | 3 | Region code: 0 main, 1 zero read, 2 zero write, 3 scratchpad, 4 vector window, 7 none |
| rsp_offset | output | 32 | Byte offset inside the selected region |
| rsp_buserr | output | 1 | Decode failure for this response |
| buserr_flag | output | 1 | Sticky bus-error flag |
| chan_stat | output | NUM_CH (10) | Sticky per-channel error status bits |
| start_clr | output | NUM_CH (10) | One-cycle pulse that clears the start bit of the failing channel |

## Verification
On every cycle the assertions check four things: the one-cycle latency, offset alignment, the shape of an error response, and the sticky behaviour of the flag and status bits. They also check that the start-clear pulse is one-hot and tied to error responses, and that the scratchpad flag wins on the normal path. Some behaviours only the bench's scenarios can show. These are the exact region boundaries (the last main-RAM quadword, the alias end at 0x1000_4000, the vector window edges) and the differences between the two paths for the same address. The bench also shows that only the requesting channel's status bit and clear pulse respond.

// File: rtl/dma_rgn_pkg.sv
package dma_rgn_pkg;
   localparam int unsigned ADDR_W = 32;
   localparam logic [ADDR_W-1:0] PHYS_MASK = 32'h1FFF_FFF0;
   localparam logic [ADDR_W-1:0] IO_BASE   = 32'h1000_0000;

   typedef enum logic [2:0] {
      RGN_MAIN    = 3'd0,
      RGN_ZERO_RD = 3'd1,
      RGN_ZERO_WR = 3'd2,
      RGN_SPAD    = 3'd3,
      RGN_VU      = 3'd4,
      RGN_NONE    = 3'd7
   } rgn_e;

   typedef struct packed {
      logic              hit;
      rgn_e              rgn;
      logic [ADDR_W-1:0] ofs;
   } dec_t;
endpackage

// File: rtl/dma_low_decode.sv
module dma_low_decode
   import dma_rgn_pkg::*;
#(
   parameter logic [31:0] MAIN_BYTES = 32'h0200_0000
) (
   input  logic [ADDR_W-1:0] phys,
   input  logic              wr,
   output dec_t              res
);
   always_comb begin
      res.hit = (phys < IO_BASE);
      res.rgn = RGN_NONE;
      res.ofs = '0;
      if (phys < MAIN_BYTES) begin
         res.rgn = RGN_MAIN;
         res.ofs = phys;
      end else if (phys < IO_BASE) begin
         res.rgn = wr ? RGN_ZERO_WR : RGN_ZERO_RD;
      end
   end
endmodule

// File: rtl/dma_norm_path.sv
module dma_norm_path
   import dma_rgn_pkg::*;
#(
   parameter logic [31:0] MAIN_BYTES = 32'h0200_0000,
   parameter logic [31:0] SPAD_BYTES = 32'h0000_4000
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   output dec_t              res
);
   localparam logic [ADDR_W-1:0] SPAD_MASK = (SPAD_BYTES - 32'd1) & 32'hFFFF_FFF0;
   localparam logic [ADDR_W-1:0] ALIAS_END = IO_BASE + SPAD_BYTES;

   logic [ADDR_W-1:0] phys;
   dec_t              low;

   assign phys = addr & PHYS_MASK;

   dma_low_decode #(.MAIN_BYTES(MAIN_BYTES)) u_low (
      .phys (phys),
      .wr   (wr),
      .res  (low)
   );

   always_comb begin
      res.hit = 1'b0;
      res.rgn = RGN_NONE;
      res.ofs = '0;
      if (addr[ADDR_W-1]) begin
         res.hit = 1'b1;
         res.rgn = RGN_SPAD;
         res.ofs = addr & SPAD_MASK;
      end else if (low.hit) begin
         res = low;
      end else if (phys < ALIAS_END) begin
         res.hit = 1'b1;
         res.rgn = RGN_SPAD;
         res.ofs = phys & SPAD_MASK;
      end
   end
endmodule

// File: rtl/dma_spad_path.sv
module dma_spad_path
   import dma_rgn_pkg::*;
#(
   parameter logic [31:0] MAIN_BYTES = 32'h0200_0000,
   parameter logic [31:0] SPAD_BYTES = 32'h0000_4000,
   parameter logic [31:0] VU_BASE    = 32'h1100_4000,
   parameter logic [31:0] VU_END     = 32'h1101_0000
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   output dec_t              res
);
   localparam logic [ADDR_W-1:0] SPAD_MASK = (SPAD_BYTES - 32'd1) & 32'hFFFF_FFF0;

   logic [ADDR_W-1:0] phys;
   logic              spad_tag;
   dec_t              low;

   assign phys     = addr & PHYS_MASK;
   assign spad_tag = &addr[ADDR_W-2:ADDR_W-4];

   dma_low_decode #(.MAIN_BYTES(MAIN_BYTES)) u_low (
      .phys (phys),
      .wr   (wr),
      .res  (low)
   );

   always_comb begin
      res.hit = 1'b0;
      res.rgn = RGN_NONE;
      res.ofs = '0;
      if (spad_tag) begin
         res.hit = 1'b1;
         res.rgn = RGN_SPAD;
         res.ofs = addr & SPAD_MASK;
      end else if (low.hit) begin
         res = low;
      end else if (phys >= VU_BASE && phys < VU_END) begin
         res.hit = 1'b1;
         res.rgn = RGN_VU;
         res.ofs = phys - VU_BASE;
      end
   end
endmodule

// File: rtl/dma_fault_track.sv
module dma_fault_track #(
   parameter int unsigned NUM_CH = 10,
   parameter int unsigned CH_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fault_valid,
   input  logic [CH_W-1:0]   fault_ch,
   output logic              flag,
   output logic [NUM_CH-1:0] stat,
   output logic [NUM_CH-1:0] clr
);
   logic [NUM_CH-1:0] sel;

   for (genvar g = 0; g < NUM_CH; g++) begin : g_sel
      assign sel[g] = fault_valid && (fault_ch == CH_W'(g));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag <= 1'b0;
         stat <= '0;
         clr  <= '0;
      end else begin
         if (fault_valid) flag <= 1'b1;
         stat <= stat | sel;
         clr  <= sel;
      end
   end
endmodule

// File: rtl/dma_addr_decoder.sv
module dma_addr_decoder
   import dma_rgn_pkg::*;
#(
   parameter int unsigned NUM_CH     = 10,
   parameter int unsigned SPAD_CH    = 8,
   parameter logic [31:0] MAIN_BYTES = 32'h0200_0000,
   parameter logic [31:0] SPAD_BYTES = 32'h0000_4000,
   parameter logic [31:0] VU_BASE    = 32'h1100_4000,
   parameter logic [31:0] VU_END     = 32'h1101_0000,
   localparam int unsigned CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [31:0]       req_addr,
   input  logic [CH_W-1:0]   req_ch,
   input  logic              req_write,
   output logic              rsp_valid,
   output logic [2:0]        rsp_region,
   output logic [31:0]       rsp_offset,
   output logic              rsp_buserr,
   output logic              buserr_flag,
   output logic [NUM_CH-1:0] chan_stat,
   output logic [NUM_CH-1:0] start_clr
);
   if (NUM_CH < 1) begin : g_bad_ch
      $error("NUM_CH must be at least 1");
   end
   if (MAIN_BYTES == 0 || MAIN_BYTES > IO_BASE || MAIN_BYTES[3:0] != 4'd0) begin : g_bad_main
      $error("MAIN_BYTES must be quadword aligned and within the low physical space");
   end
   if (SPAD_BYTES < 32'd16 || (SPAD_BYTES & (SPAD_BYTES - 32'd1)) != 0) begin : g_bad_spad
      $error("SPAD_BYTES must be a power of two of at least one quadword");
   end
   if (VU_BASE >= VU_END || VU_BASE < IO_BASE) begin : g_bad_vu
      $error("vector window must be a non-empty range above the I/O base");
   end

   dec_t norm_res;
   dec_t alt_res;
   dec_t pick;
   logic use_alt;

   dma_norm_path #(
      .MAIN_BYTES (MAIN_BYTES),
      .SPAD_BYTES (SPAD_BYTES)
   ) u_norm (
      .addr (req_addr),
      .wr   (req_write),
      .res  (norm_res)
   );

   if (SPAD_CH < NUM_CH) begin : g_alt
      dma_spad_path #(
         .MAIN_BYTES (MAIN_BYTES),
         .SPAD_BYTES (SPAD_BYTES),
         .VU_BASE    (VU_BASE),
         .VU_END     (VU_END)
      ) u_alt (
         .addr (req_addr),
         .wr   (req_write),
         .res  (alt_res)
      );
      assign use_alt = (req_ch == CH_W'(SPAD_CH));
   end else begin : g_no_alt
      assign alt_res = '{hit: 1'b0, rgn: RGN_NONE, ofs: '0};
      assign use_alt = 1'b0;
   end

   assign pick = use_alt ? alt_res : norm_res;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_region <= RGN_NONE;
         rsp_offset <= '0;
         rsp_buserr <= 1'b0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_buserr <= !pick.hit;
            rsp_region <= pick.hit ? pick.rgn : RGN_NONE;
            rsp_offset <= pick.hit ? pick.ofs : '0;
         end
      end
   end

   dma_fault_track #(
      .NUM_CH (NUM_CH),
      .CH_W   (CH_W)
   ) u_fault (
      .clk         (clk),
      .rst_n       (rst_n),
      .fault_valid (req_valid && !pick.hit),
      .fault_ch    (req_ch),
      .flag        (buserr_flag),
      .stat        (chan_stat),
      .clr         (start_clr)
   );
endmodule

// File: rtl/dma_addr_decoder_chk.sv
module dma_addr_decoder_chk #(
   parameter int unsigned NUM_CH  = 10,
   parameter int unsigned SPAD_CH = 8,
   parameter int unsigned CH_W    = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [31:0]       req_addr,
   input logic [CH_W-1:0]   req_ch,
   input logic              rsp_valid,
   input logic [2:0]        rsp_region,
   input logic [31:0]       rsp_offset,
   input logic              rsp_buserr,
   input logic              buserr_flag,
   input logic [NUM_CH-1:0] chan_stat,
   input logic [NUM_CH-1:0] start_clr
);
   AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid); // R12
   AST_RSP_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid); // R12
   AST_OFS_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> rsp_offset[3:0] == 4'd0); // R1
   AST_SPAD_FLAG_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_addr[31] && req_ch != CH_W'(SPAD_CH)) |=> (rsp_region == 3'd3 && !rsp_buserr)); // R2
   AST_SPAD_OFS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_region == 3'd3) |-> rsp_offset[31:14] == 18'd0); // R5
   AST_ZERO_OFS: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && (rsp_region == 3'd1 || rsp_region == 3'd2)) |-> rsp_offset == 32'd0); // R4
   AST_ERR_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_buserr) |-> (rsp_region == 3'd7 && rsp_offset == 32'd0)); // R8
   AST_FLAG_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_buserr) |-> buserr_flag); // R9
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      buserr_flag |=> buserr_flag); // R9
   AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((chan_stat & $past(chan_stat)) == $past(chan_stat))); // R10
   AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(start_clr)); // R11
   AST_CLR_ONLY_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (|start_clr) |-> (rsp_valid && rsp_buserr)); // R11
   AST_ERR_HAS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_buserr) |-> $countones(start_clr) == 1); // R11
endmodule

bind dma_addr_decoder dma_addr_decoder_chk #(
   .NUM_CH  (NUM_CH),
   .SPAD_CH (SPAD_CH),
   .CH_W    (CH_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_addr    (req_addr),
   .req_ch      (req_ch),
   .rsp_valid   (rsp_valid),
   .rsp_region  (rsp_region),
   .rsp_offset  (rsp_offset),
   .rsp_buserr  (rsp_buserr),
   .buserr_flag (buserr_flag),
   .chan_stat   (chan_stat),
   .start_clr   (start_clr)
);

// File: tb/dma_addr_decoder_test.sv
`timescale 1ns/1ps
module dma_addr_decoder_test;
   localparam int unsigned NCH  = 10;
   localparam int unsigned SPCH = 8;
   localparam int unsigned CW   = 4;
   localparam logic [31:0] MAIN = 32'h0200_0000;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            req_valid = 1'b0;
   logic [31:0]     req_addr = '0;
   logic [CW-1:0]   req_ch = '0;
   logic            req_write = 1'b0;
   logic            rsp_valid;
   logic [2:0]      rsp_region;
   logic [31:0]     rsp_offset;
   logic            rsp_buserr;
   logic            buserr_flag;
   logic [NCH-1:0]  chan_stat;
   logic [NCH-1:0]  start_clr;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;
   logic            exp_flag = 1'b0;
   logic [NCH-1:0]  exp_stat = '0;

   always #4 clk = ~clk;

   dma_addr_decoder uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_ch(req_ch), .req_write(req_write), .rsp_valid(rsp_valid),
      .rsp_region(rsp_region), .rsp_offset(rsp_offset), .rsp_buserr(rsp_buserr),
      .buserr_flag(buserr_flag), .chan_stat(chan_stat), .start_clr(start_clr)
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // returns {err, region[2:0], offset[31:0]}
   function automatic logic [35:0] expect_of(input logic [31:0] a, input int ch, input logic w);
      logic [31:0] m;
      m = a & 32'h1FFF_FFF0;
      if (ch == SPCH) begin
         if (a[30:28] == 3'b111)                         return {1'b0, 3'd3, a & 32'h3FF0};
         if (m < MAIN)                                   return {1'b0, 3'd0, m};
         if (m < 32'h1000_0000)                          return {1'b0, w ? 3'd2 : 3'd1, 32'd0};
         if (m >= 32'h1100_4000 && m < 32'h1101_0000)    return {1'b0, 3'd4, m - 32'h1100_4000};
         return {1'b1, 3'd7, 32'd0};
      end
      if (a[31])                                         return {1'b0, 3'd3, a & 32'h3FF0};
      if (m < MAIN)                                      return {1'b0, 3'd0, m};
      if (m < 32'h1000_0000)                             return {1'b0, w ? 3'd2 : 3'd1, 32'd0};
      if (m < 32'h1000_4000)                             return {1'b0, 3'd3, m & 32'h3FF0};
      return {1'b1, 3'd7, 32'd0};
   endfunction

   task automatic do_req(input logic [31:0] a, input int ch, input logic w, input string tag);
      logic [35:0] e;
      logic [NCH-1:0] eclr;
      e = expect_of(a, ch, w);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_ch = CW'(ch); req_write = w;
      @(negedge clk);
      req_valid = 1'b0;
      eclr = '0;
      if (e[35]) begin
         exp_flag = 1'b1;
         exp_stat[ch] = 1'b1;
         eclr[ch] = 1'b1;
      end
      chk(rsp_valid === 1'b1, {tag, " R12 rsp_valid"}, 64'(rsp_valid), 64'd1);
      chk(rsp_buserr === e[35] && rsp_region === e[34:32] && rsp_offset === e[31:0],
          tag, {27'd0, rsp_buserr, rsp_region, rsp_offset}, {27'd0, e});
      chk(start_clr === eclr, {tag, " R11 start_clr"}, 64'(start_clr), 64'(eclr));
      chk(buserr_flag === exp_flag && chan_stat === exp_stat, {tag, " R9 R10 flag/stat"},
          {53'd0, buserr_flag, chan_stat}, {53'd0, exp_flag, exp_stat});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog R12 actual=%0d expected=%0d", 1, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2718));
      repeat (3) @(negedge clk);
      chk(rsp_valid === 1'b0 && buserr_flag === 1'b0 && chan_stat === '0 && start_clr === '0,
          "R12 reset state", {52'd0, rsp_valid, buserr_flag, start_clr}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(rsp_valid === 1'b0, "R12 idle after reset", 64'(rsp_valid), 64'd0);

      // directed corners
      do_req(32'h0000_001F, 0, 1'b0, "R1 low bits dropped");
      do_req(32'h01FF_FFF0, 1, 1'b0, "R3 last main quadword");
      do_req(32'h6000_0010, 3, 1'b0, "R3 upper bits masked");
      do_req(32'h0200_0000, 2, 1'b0, "R4 zero read start");
      do_req(32'h0FFF_FFF0, 2, 1'b1, "R4 zero write end");
      do_req(32'h8000_1234, 0, 1'b0, "R2 flag bit normal");
      do_req(32'hF100_4000, 5, 1'b1, "R2 flag bit wraps offset");
      do_req(32'h1000_0000, 4, 1'b0, "R5 alias start");
      do_req(32'h1000_3FF0, 4, 1'b0, "R5 alias end");
      do_req(32'h1000_4000, 6, 1'b0, "R8 past alias");
      do_req(32'h1100_4000, 0, 1'b0, "R8 vu window normal path");
      do_req(32'h7000_0010, SPCH, 1'b0, "R6 tag on spad channel");
      do_req(32'hF000_2220, SPCH, 1'b1, "R6 tag with bit31");
      do_req(32'h8000_1234, SPCH, 1'b0, "R6 bit31 alone on spad channel");
      do_req(32'h1000_0000, SPCH, 1'b0, "R7 no alias on spad channel");
      do_req(32'h1100_3FF0, SPCH, 1'b0, "R7 below vu window");
      do_req(32'h1100_4000, SPCH, 1'b0, "R7 vu window start");
      do_req(32'h1100_FFF0, SPCH, 1'b1, "R7 vu window end");
      do_req(32'h1101_0000, SPCH, 1'b0, "R7 past vu window");
      @(negedge clk);
      chk(rsp_valid === 1'b0 && start_clr === '0, "R11 R12 quiet cycle",
          {53'd0, rsp_valid, start_clr}, 64'd0);

      // constrained random
      for (int i = 0; i < 400; i++) begin
         logic [31:0] a;
         int ch;
         ch = $urandom_range(0, NCH - 1);
         case ($urandom_range(0, 7))
            0: a = $urandom;
            1: a = $urandom_range(0, MAIN - 1);
            2: a = $urandom_range(MAIN, 32'h0FFF_FFFF);
            3: a = 32'h1000_0000 + $urandom_range(0, 32'h7FFF);
            4: a = 32'h1100_0000 + $urandom_range(0, 32'h1_FFFF);
            5: a = {1'b0, 3'b111, 28'($urandom)};
            6: a = {1'b1, 31'($urandom)};
            default: a = {3'($urandom), 29'h1000_0000 + 29'($urandom_range(0, 32'h0100_FFFF))};
         endcase
         if (i % 5 == 0) ch = SPCH;
         do_req(a, ch, 1'($urandom), "R1-mix random");
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule